// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit

This block is a first-in first-out buffer for 9-bit words. It has a write port and a read port. Each port runs on its own free-running clock with its own enable. The two clocks may come from one source or run at unrelated rates. Each side keeps its own binary and Gray pointer. The Gray pointer crosses into the other domain through a two-flop synchronizer. The full flag and the almost-full flag are computed on the write side, from the write pointer and the synchronized read pointer. The empty flag and the almost-empty flag are computed on the read side in the same way.

Two offset registers set the almost flags. The almost-empty offset lives in the read domain and the almost-full offset lives in the write domain. Each is loaded by a one-cycle strobe on its own clock and returns to a default value on reset. A read delivers the next word into an output register after the read clock edge. An output enable switches the data output between that register and high impedance.

A retransmit strobe on the read side rewinds the read pointer to the first word written since reset. The stored data is kept, so it can be read again. Retransmit is honoured only while that first word is still held, which means that no more than DEPTH words have been written since reset.

Top module: `xclk_fifo`

## Requirements
- R1: While wr_en is high and full is low, each rising wclk edge stores wr_data (9 bits). Holding wr_en high stores one word per cycle, and the words are read back in write order.
- R2: A rising rclk edge with rd_en high, empty low and rexmit low loads the next stored word into the output register, which appears on rd_data after that edge. Otherwise the register holds its value.
- R3: When oe is low, rd_data is high impedance. When oe is high, rd_data drives the output register.
- R4: empty is high after reset. For a write at wclk edge k with the clocks tied, empty goes low only after edge k+2, which is the synchronizer latency.
- R5: full is high when DEPTH words are stored as seen by the write side. A write while full is ignored and its word never appears at the output.
- R6: A read while empty is ignored: rd_data and the read position do not change.
- R7: almost_empty is high when the stored count seen by the read side is at or below the almost-empty offset. almost_full is high when the free space seen by the write side is at or below the almost-full offset.
- R8: A high ae_set at a rising rclk edge loads ae_level as the almost-empty offset. A high af_set at a rising wclk edge loads af_level as the almost-full offset. The flags use the new value from the next cycle.
- R9: A high rexmit at a rising rclk edge rewinds the read position to the first word written since reset, without losing stored data. rexmit takes priority over rd_en in the same cycle. empty and almost_empty follow the new position.
- R10: Once more than DEPTH words have been written since reset, and two rclk edges have passed, rexmit is ignored.
- R11: With wclk and rclk at unrelated periods, every accepted word is read out exactly once, in order.
- R12: The active-low asynchronous reset rst_n clears both pointers and the output register to zero and sets both offsets to OFF_DEF (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Word to store |
| af_set | input | 1 | Load strobe for the almost-full offset (wclk) |
| af_level | input | AW+1 | New almost-full offset |
| rd_en | input | 1 | Read request |
| rexmit | input | 1 | Retransmit strobe (rclk) |
| oe | input | 1 | Output enable |
| rd_data | output | 9 | Read word, or high impedance |
| ae_set | input | 1 | Load strobe for the almost-empty offset (rclk) |
| ae_level | input | AW+1 | New almost-empty offset |
| empty | output | 1 | No word available to the read side |
| almost_empty | output | 1 | Stored count at or below its offset |
| full | output | 1 | No free space seen by the write side |
| almost_full | output | 1 | Free space at or below its offset |

## Verification
With the clocks tied, a behavioural model is compared against the flags and data on every cycle. The stimulus covers isolated writes, which expose the two-edge empty latency, and overlapping writes and reads. It also holds wr_en high past full and rd_en high past empty, which separates accepted requests from ignored ones. Retransmit is tried three ways: inside its window, together with a read request, and after the window has closed, which tells rewind, priority and refusal apart. A final run with unrelated clock periods checks ordering and completeness through a scoreboard, where pointer crossing errors would lose or duplicate words.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  localparam int PMAX = 16;
  typedef logic [PMAX-1:0] pword_t;

  function automatic pword_t to_gray(pword_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic pword_t from_gray(pword_t g);
    pword_t b;
    b[PMAX-1] = g[PMAX-1];
    for (int i = PMAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // distance from b up to a, modulo 2**pw
  function automatic pword_t span(pword_t a, pword_t b, int unsigned pw);
    pword_t m;
    m = (pword_t'(1) << pw) - pword_t'(1);
    return (a - b) & m;
  endfunction
endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/xfifo_wctl.sv
module xfifo_wctl
  import xfifo_pkg::*;
#(
  parameter int AW      = 4,
  parameter int OFF_DEF = 2
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rq_gray,
  input  logic          af_set,
  input  logic [AW:0]   af_level,
  output logic [AW:0]   wptr_bin,
  output logic [AW:0]   wptr_gray,
  output logic [AW-1:0] waddr,
  output logic          wr_fire,
  output logic          full,
  output logic          almost_full,
  output logic          mark_gone
);
  localparam int PW = AW + 1;
  localparam logic [AW:0] DEPTH_P = PW'(2 ** AW);
  localparam logic [AW:0] OFF_P   = PW'(OFF_DEF);

  logic [AW:0] rq_bin, used, room, af_off, wptr_nx, wgray_nx;

  always_comb begin
    pword_t t;
    t        = from_gray(pword_t'(rq_gray));
    rq_bin   = t[AW:0];
    t        = span(pword_t'(wptr_bin), pword_t'(rq_bin), PW);
    used     = t[AW:0];
    wptr_nx  = wptr_bin + PW'(1);
    t        = to_gray(pword_t'(wptr_nx));
    wgray_nx = t[AW:0];
  end

  assign full        = (used == DEPTH_P);
  assign room        = DEPTH_P - used;
  assign almost_full = (room <= af_off);
  assign wr_fire     = wr_en & ~full;
  assign waddr       = wptr_bin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
      mark_gone <= 1'b0;
      af_off    <= OFF_P;
    end else begin
      if (wr_fire) begin
        wptr_bin  <= wptr_nx;
        wptr_gray <= wgray_nx;
        // the write that reuses slot 0 of the first lap ends the replay window
        if (wptr_bin == DEPTH_P) mark_gone <= 1'b1;
      end
      if (af_set) af_off <= af_level;
    end
  end
endmodule

// File: rtl/xfifo_rctl.sv
module xfifo_rctl
  import xfifo_pkg::*;
#(
  parameter int AW      = 4,
  parameter int OFF_DEF = 2
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rexmit,
  input  logic [AW:0]   wq_gray,
  input  logic          gone_s,
  input  logic          ae_set,
  input  logic [AW:0]   ae_level,
  output logic [AW:0]   rptr_bin,
  output logic [AW:0]   rptr_gray,
  output logic [AW-1:0] raddr,
  output logic          rd_fire,
  output logic          rx_fire,
  output logic          empty,
  output logic          almost_empty
);
  localparam int PW = AW + 1;
  localparam logic [AW:0] OFF_P = PW'(OFF_DEF);

  logic [AW:0] wq_bin, held, ae_off, rptr_nx, rgray_nx;

  assign rx_fire = rexmit & ~gone_s;
  assign rd_fire = rd_en & ~empty & ~rexmit;

  always_comb begin
    pword_t t;
    t      = from_gray(pword_t'(wq_gray));
    wq_bin = t[AW:0];
    t      = span(pword_t'(wq_bin), pword_t'(rptr_bin), PW);
    held   = t[AW:0];
    if (rx_fire)      rptr_nx = '0;
    else if (rd_fire) rptr_nx = rptr_bin + PW'(1);
    else              rptr_nx = rptr_bin;
    t        = to_gray(pword_t'(rptr_nx));
    rgray_nx = t[AW:0];
  end

  assign empty        = (held == '0);
  assign almost_empty = (held <= ae_off);
  assign raddr        = rptr_bin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      ae_off    <= OFF_P;
    end else begin
      rptr_bin  <= rptr_nx;
      rptr_gray <= rgray_nx;
      if (ae_set) ae_off <= ae_level;
    end
  end
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int AW      = 4,
  parameter int DW      = 9,
  parameter int OFF_DEF = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          af_set,
  input  logic [AW:0]   af_level,
  input  logic          rd_en,
  input  logic          rexmit,
  input  logic          oe,
  output logic [DW-1:0] rd_data,
  input  logic          ae_set,
  input  logic [AW:0]   ae_level,
  output logic          empty,
  output logic          almost_empty,
  output logic          full,
  output logic          almost_full
);
  // named internal events, observed by the bound checker
  logic [AW:0]   wptr_bin, wptr_gray, rptr_bin, rptr_gray, rq_gray, wq_gray;
  logic [AW-1:0] waddr, raddr;
  logic          wr_fire, rd_fire, rx_fire, mark_gone, gone_s;
  logic [DW-1:0] rd_q;

  xfifo_wctl #(.AW(AW), .OFF_DEF(OFF_DEF)) u_wctl (
    .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .rq_gray(rq_gray),
    .af_set(af_set), .af_level(af_level),
    .wptr_bin(wptr_bin), .wptr_gray(wptr_gray), .waddr(waddr),
    .wr_fire(wr_fire), .full(full), .almost_full(almost_full),
    .mark_gone(mark_gone)
  );

  xfifo_rctl #(.AW(AW), .OFF_DEF(OFF_DEF)) u_rctl (
    .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en), .rexmit(rexmit),
    .wq_gray(wq_gray), .gone_s(gone_s),
    .ae_set(ae_set), .ae_level(ae_level),
    .rptr_bin(rptr_bin), .rptr_gray(rptr_gray), .raddr(raddr),
    .rd_fire(rd_fire), .rx_fire(rx_fire),
    .empty(empty), .almost_empty(almost_empty)
  );

  xfifo_sync #(.W(AW + 1)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rptr_gray), .q(rq_gray)
  );

  xfifo_sync #(.W(AW + 1)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wptr_gray), .q(wq_gray)
  );

  xfifo_sync #(.W(1)) u_gone (
    .clk(rclk), .rst_n(rst_n), .d(mark_gone), .q(gone_s)
  );

  xfifo_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .rst_n(rst_n), .re(rd_fire), .raddr(raddr), .rdata(rd_q)
  );

  assign rd_data = oe ? rd_q : {DW{1'bz}};
endmodule

// File: rtl/xfifo_chk.sv
module xfifo_chk #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rexmit,
  input logic          full,
  input logic          almost_full,
  input logic          empty,
  input logic          almost_empty,
  input logic          wr_fire,
  input logic          rx_fire,
  input logic [AW:0]   wptr_bin,
  input logic [AW:0]   rptr_bin,
  input logic [DW-1:0] rd_q
);
  localparam int PW = AW + 1;

  // R1
  write_advance_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_fire |=> (wptr_bin == PW'($past(wptr_bin) + PW'(1))));

  // R5
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && wr_en) |=> $stable(wptr_bin));

  // R6
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (empty && rd_en && !rexmit) |=> ($stable(rptr_bin) && $stable(rd_q)));

  // R9
  rewind_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rx_fire |=> (rptr_bin == '0));

  // R7
  full_af_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);

  // R7
  empty_ae_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);
endmodule

bind xclk_fifo xfifo_chk #(.AW(AW), .DW(DW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .rexmit(rexmit), .full(full), .almost_full(almost_full), .empty(empty),
  .almost_empty(almost_empty), .wr_fire(wr_fire), .rx_fire(rx_fire),
  .wptr_bin(wptr_bin), .rptr_bin(rptr_bin), .rd_q(rd_q)
);

// File: tb/tb_xclk_fifo.sv
module tb_xclk_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int ALT_PERIOD = 14;
  localparam int AW    = 4;
  localparam int DEPTH = 16;

  logic clk_a = 0, clk_b = 0, tied = 1, model_on = 1;
  always #(CLK_PERIOD / 2) clk_a = ~clk_a;
  always #(ALT_PERIOD / 2) clk_b = ~clk_b;
  wire wclk = clk_a;
  wire rclk = tied ? clk_a : clk_b;

  logic rst_n = 0, wr_en = 0, rd_en = 0, rexmit = 0, oe = 1;
  logic ae_set = 0, af_set = 0;
  logic [8:0] wr_data = '0;
  logic [AW:0] ae_level = '0, af_level = '0;
  wire [8:0] rd_data;
  wire empty, almost_empty, full, almost_full;

  xclk_fifo dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .af_set(af_set), .af_level(af_level), .rd_en(rd_en), .rexmit(rexmit),
    .oe(oe), .rd_data(rd_data), .ae_set(ae_set), .ae_level(ae_level),
    .empty(empty), .almost_empty(almost_empty), .full(full),
    .almost_full(almost_full)
  );

  int n_run = 0, n_fail = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // behavioural reference for tied clocks: absolute word indices
  int wp, rp, wq1, wq2, rq1, rq2, aeo, afo;
  bit lw, lr1, lr2;
  logic [8:0] qm;
  logic [8:0] log_q[$];

  always @(posedge clk_a or negedge rst_n) begin : mdl
    bit f_pre, e_pre, lw_n;
    int nw, nr;
    if (!rst_n) begin
      wp = 0; rp = 0; wq1 = 0; wq2 = 0; rq1 = 0; rq2 = 0;
      aeo = 2; afo = 2; lw = 0; lr1 = 0; lr2 = 0; qm = '0;
      log_q.delete();
    end else if (tied) begin
      f_pre = ((wp - rq2) == DEPTH);
      e_pre = (rp == wq2);
      nw = wp; nr = rp; lw_n = lw;
      if (wr_en && !f_pre) begin
        log_q.push_back(wr_data);
        if (wp == DEPTH) lw_n = 1;
        nw = wp + 1;
      end
      if (rexmit) begin
        if (!lr2) nr = 0;
      end else if (rd_en && !e_pre) begin
        qm = log_q[rp];
        nr = rp + 1;
      end
      wq2 = wq1; wq1 = wp; rq2 = rq1; rq1 = rp; lr2 = lr1; lr1 = lw;
      if (ae_set) aeo = int'(ae_level);
      if (af_set) afo = int'(af_level);
      wp = nw; rp = nr; lw = lw_n;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk_a) begin
    #2;
    if (rst_n && tied && model_on) begin
      check("R4", "empty", 32'(empty), 32'(rp == wq2));
      check("R5", "full", 32'(full), 32'((wp - rq2) == DEPTH));
      check("R7", "almost_empty", 32'(almost_empty), 32'((wq2 - rp) <= aeo));
      check("R7", "almost_full", 32'(almost_full), 32'((DEPTH - (wp - rq2)) <= afo));
      if (oe) check("R1/R2", "rd_data", 32'(rd_data), 32'(qm));
    end
  end

  task automatic step(input bit w, input logic [8:0] d, input bit r, input bit x);
    @(negedge clk_a);
    wr_en = w; wr_data = d; rd_en = r; rexmit = x; ae_set = 0; af_set = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  logic [8:0] sb[$];

  initial begin
    repeat (3) @(negedge clk_a);
    rst_n = 1;
    #1;
    // R12 reset state
    check("R12", "empty", 32'(empty), 1);
    check("R12", "full", 32'(full), 0);
    check("R12", "almost_empty", 32'(almost_empty), 1);
    check("R12", "almost_full", 32'(almost_full), 0);
    check("R12", "rd_data", 32'(rd_data), 0);

    // R6 read while empty
    step(0, '0, 1, 0);
    idle(1);
    check("R6", "rd_data after empty read", 32'(rd_data), 0);

    // R4 two-edge latency of empty
    step(1, 9'h1A5, 0, 0);
    idle(1); check("R4", "empty after k", 32'(empty), 1);
    idle(1); check("R4", "empty after k+1", 32'(empty), 1);
    idle(1); check("R4", "empty after k+2", 32'(empty), 0);

    step(1, 9'h033, 0, 0);
    step(1, 9'h144, 1, 0);
    idle(1); check("R2", "first word", 32'(rd_data), 32'h1A5);
    step(0, '0, 1, 0);
    step(0, '0, 1, 0);
    idle(3);
    check("R2", "third word", 32'(rd_data), 32'h144);

    // R9 retransmit
    step(0, '0, 0, 1);
    idle(1); check("R9", "empty after rewind", 32'(empty), 0);
    step(0, '0, 1, 0);
    idle(1); check("R9", "replayed first word", 32'(rd_data), 32'h1A5);
    step(0, '0, 1, 1);
    idle(1); check("R9", "read blocked by rexmit", 32'(rd_data), 32'h1A5);
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0);
    idle(3);
    check("R9", "replay end", 32'(rd_data), 32'h144);

    // R8 offsets
    @(negedge clk_a);
    ae_set = 1; ae_level = 5; af_set = 1; af_level = 3;
    idle(1);

    // R5 hold write past full
    for (int i = 0; i < 20; i++) step(1, 9'(9'h100 + i), 0, 0);
    idle(3);
    check("R5", "full after fill", 32'(full), 1);
    check("R7", "almost_full after fill", 32'(almost_full), 1);
    for (int i = 0; i < 20; i++) step(0, '0, 1, 0);
    idle(3);
    check("R6", "held word after over-read", 32'(rd_data), 32'h10F);
    check("R6", "empty after drain", 32'(empty), 1);

    // R10 retransmit refused after more than DEPTH writes
    step(0, '0, 0, 1);
    idle(2);
    check("R10", "empty stays", 32'(empty), 1);
    step(0, '0, 1, 0);
    idle(1);
    check("R10", "rd_data stays", 32'(rd_data), 32'h10F);

    // R3 output enable
    @(negedge clk_a);
    oe = 0; #1;
    n_run++;
    if (rd_data !== 9'bz) begin
      n_fail++;
      $display("FAIL R3 rd_data: actual %0h expected zzz", rd_data);
    end
    oe = 1; #1;
    check("R3", "rd_data driven", 32'(rd_data), 32'h10F);

    // R8 then R12 mid-run reset
    for (int i = 0; i < 4; i++) step(1, 9'(9'h1E0 + i), 0, 0);
    idle(3);
    check("R8", "almost_empty with offset 5", 32'(almost_empty), 1);
    @(negedge clk_a);
    rst_n = 0; #1;
    check("R12", "empty in reset", 32'(empty), 1);
    check("R12", "rd_data in reset", 32'(rd_data), 0);
    check("R12", "full in reset", 32'(full), 0);
    repeat (2) @(negedge clk_a);
    rst_n = 1;
    for (int i = 0; i < 4; i++) step(1, 9'(9'h0C0 + i), 0, 0);
    idle(3);
    check("R12", "almost_empty with default offset", 32'(almost_empty), 0);

    // R11 unrelated clocks
    @(negedge clk_a);
    rst_n = 0; tied = 0; model_on = 0;
    wr_en = 0; rd_en = 0; rexmit = 0;
    repeat (3) @(negedge clk_a);
    rst_n = 1;
    fork
      begin : writer
        int k = 0;
        while (k < 40) begin
          @(negedge wclk);
          if (!full) begin
            wr_en = 1; wr_data = 9'(k * 7 + 3);
            sb.push_back(9'(k * 7 + 3));
            k++;
          end else wr_en = 0;
        end
        @(negedge wclk);
        wr_en = 0;
      end
      begin : reader
        int got = 0, guard = 0;
        bit pend = 0;
        while (got < 40 && guard < 3000) begin
          @(negedge rclk);
          guard++;
          if (pend) begin
            check("R11", "ordered word", 32'(rd_data), 32'(sb.pop_front()));
            got++;
          end
          pend = !empty && (got + 1 < 40 || !pend) && (got < 40);
          rd_en = pend;
        end
        rd_en = 0;
        check("R11", "words received", 32'(got), 40);
      end
    join
    report();
  end
endmodule